// File: doc/BRIEF.md
# Configurable Audio Serial Transmitter

This block turns parallel audio samples into a serial stream and generates the two timing lines that go with it: a bit clock and a frame sync. The bit clock is made from the system clock by a programmable divider. Samples arrive as a left/right pair over a valid/ready handshake into a one-entry holding buffer. Each frame takes one pair from that buffer. If the buffer is empty when a frame begins, the block sends the previous pair again and records the event in a sticky flag.

A static configuration picks one of three framings. In the stereo format with a one-bit delay, frame sync low marks the left slot. In the left-aligned stereo format, frame sync high marks the left slot and there is no delay. The mono pulse format puts a frame sync pulse at the start of each frame; that pulse is short or long, and its polarity is selectable. Sample width and slot width are set independently. A sample narrower than its slot is sent from the most significant end and followed by zeros. The mono format can also reverse the bit order and can delay the data by one bit. Change the configuration only while reset is held.

Top module: `audio_serial_tx`

## Requirements
- R1: `bclk` has a period of 2×`cfg_div` system clocks (`cfg_div` ≥ 1), with each level lasting `cfg_div` clocks. `fsync` and `sdata` change only in the clock cycle in which `bclk` falls, and each data bit is held for one full bit-clock period.
- R2: With `cfg_fmt`=0 (stereo, delayed), the frame is 2×`cfg_slot_w` bits. `fsync` is 0 for the first `cfg_slot_w` bit periods (left) and 1 for the next `cfg_slot_w` bit periods (right).
- R3: With `cfg_fmt`=0, each slot's first (most significant) bit appears one bit period after the `fsync` edge. The bit period that follows that edge carries the last bit of the preceding slot.
- R4: With `cfg_fmt`=1 (stereo, left-aligned), `fsync` is 1 for the left slot and 0 for the right slot, and the most significant bit appears in the same bit period as the `fsync` edge.
- R5: A sample is the low `cfg_sample_w` bits (8 to 32) of its input word. When `cfg_slot_w` exceeds `cfg_sample_w`, the slot carries the sample first and then `cfg_slot_w`−`cfg_sample_w` zero bits.
- R6: With `cfg_fmt`=2 (mono pulse), the frame is `cfg_slot_w` bits and carries only the left sample, so `in_right` has no effect. The sync pulse is active during bit period 0 (short pulse, `cfg_long_sync`=0) or during bit periods 0 to `cfg_slot_w`/2−1 (long pulse, `cfg_long_sync`=1). The active level is 1 when `cfg_sync_pol`=1 and 0 when `cfg_sync_pol`=0.
- R7: With `cfg_fmt`=2, `cfg_lsb_first`=1 sends the sample least significant bit first, with the zero padding still at the end of the slot. `cfg_pcm_delay`=1 starts the data one bit period after the pulse start, and bit period 0 then carries the previous frame's last bit.
- R8: `in_ready` is high exactly when the holding buffer is empty. A pair is taken when `in_valid` and `in_ready` are both high at a clock edge. The buffer empties when a frame starts.
- R9: When a frame starts with the buffer empty, the previous pair is sent again and `underrun` goes high; it stays high until reset.
- R10: While reset is asserted, `bclk`=1, `fsync`=0, `sdata`=0, `in_ready`=1 and `underrun`=0. The first falling edge of `bclk` comes `cfg_div` clocks after reset is released and begins bit period 0 of the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Framing: 0 stereo delayed, 1 stereo left-aligned, 2 mono pulse |
| cfg_sample_w | input | 6 | Sample width in bits (8 to 32) |
| cfg_slot_w | input | 6 | Slot width in bits (cfg_sample_w to 32) |
| cfg_lsb_first | input | 1 | Mono pulse format: send least significant bit first |
| cfg_pcm_delay | input | 1 | Mono pulse format: data starts one bit after the pulse |
| cfg_long_sync | input | 1 | Mono pulse format: long pulse instead of one bit |
| cfg_sync_pol | input | 1 | Mono pulse format: active level of the pulse |
| cfg_div | input | 8 | Half period of the bit clock in system clocks |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding buffer empty |
| in_left | input | 32 | Left sample, right-aligned |
| in_right | input | 32 | Right sample, right-aligned |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync / channel select |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky: a frame started with no new pair |

## Verification
On every cycle the assertions check the following:
- `fsync` and `sdata` move only at a falling edge of `bclk`, and the divider count stays in range.
- The right-slot edge of `fsync` and the idle level of the short pulse fall in the correct bit periods.
- A waiting pair is held until a frame starts.
- `underrun` never clears, and a starved frame keeps the previous samples.

Only the bench's scenarios can show that the right bits are on the line. That covers the one-bit delay carrying the last bit of the previous slot, zero padding, reversed bit order, long-pulse length and the repeated pair after a stall. The bench's reference model predicts every output on every clock for each framing and width combination it runs.

// File: rtl/ast_pkg.sv
package ast_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'd0,
        FMT_LJ   = 2'd1,
        FMT_PCM  = 2'd2,
        FMT_RSVD = 2'd3
    } fmt_e;

endpackage

// File: rtl/ast_bclk_div.sv
module ast_bclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             bclk,
    output logic             fall
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             bclk;
    } div_state_t;

    div_state_t q, d;
    logic       tick;

    always_comb begin
        d    = q;
        tick = (q.cnt == cfg_div - DIV_W'(1));
        if (tick) begin
            d.cnt  = '0;
            d.bclk = ~q.bclk;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, bclk: 1'b1};
        else        q <= d;
    end

    assign bclk = q.bclk;
    assign fall = tick & q.bclk;

    // R1: the half-period counter never passes the programmed divide value
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < cfg_div);

    // R1: a bit clock level changes only after a full half period
    a_r1_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.bclk) |-> ($past(q.cnt) == $past(cfg_div) - DIV_W'(1)));

endmodule

// File: rtl/ast_sample_buf.sv
module ast_sample_buf #(
    parameter int MAX_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [MAX_W-1:0] in_left,
    input  logic [MAX_W-1:0] in_right,
    input  logic             load,
    output logic [MAX_W-1:0] cur_l,
    output logic [MAX_W-1:0] cur_r,
    output logic [MAX_W-1:0] nxt_l,
    output logic             underrun
);

    typedef struct packed {
        logic             pend_v;
        logic [MAX_W-1:0] pend_l;
        logic [MAX_W-1:0] pend_r;
        logic [MAX_W-1:0] cur_l;
        logic [MAX_W-1:0] cur_r;
        logic             under;
    } buf_state_t;

    buf_state_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            if (q.pend_v) begin
                d.cur_l  = q.pend_l;
                d.cur_r  = q.pend_r;
                d.pend_v = 1'b0;
            end else begin
                d.under = 1'b1;
            end
        end
        if (in_valid && !q.pend_v) begin
            d.pend_v = 1'b1;
            d.pend_l = in_left;
            d.pend_r = in_right;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready = ~q.pend_v;
    assign cur_l    = q.cur_l;
    assign cur_r    = q.cur_r;
    assign nxt_l    = d.cur_l;
    assign underrun = q.under;

    // R9: the underrun flag is sticky
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.under |=> q.under);

    // R9: a starved frame keeps the previous pair
    a_r9_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !q.pend_v) |=> ($stable(q.cur_l) && $stable(q.cur_r)));

    // R8: a waiting pair is held until a frame start consumes it
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend_v && !load) |=> (q.pend_v && $stable(q.pend_l) && $stable(q.pend_r)));

endmodule

// File: rtl/ast_frame_seq.sv
module ast_frame_seq
    import ast_pkg::*;
#(
    parameter int MAX_W = 32,
    parameter int IDX_W = 6,
    parameter int POS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    input  logic [1:0]       cfg_fmt,
    input  logic [IDX_W-1:0] cfg_sample_w,
    input  logic [IDX_W-1:0] cfg_slot_w,
    input  logic             cfg_lsb_first,
    input  logic             cfg_pcm_delay,
    input  logic             cfg_long_sync,
    input  logic             cfg_sync_pol,
    input  logic [MAX_W-1:0] cur_l,
    input  logic [MAX_W-1:0] cur_r,
    input  logic [MAX_W-1:0] nxt_l,
    output logic             load,
    output logic             fsync,
    output logic             sdata
);

    localparam int SEL_W = $clog2(MAX_W);

    typedef struct packed {
        logic             started;
        logic [POS_W-1:0] pos;
        logic             fs;
        logic             sd;
    } seq_state_t;

    seq_state_t q, d;

    logic [POS_W-1:0] slot;
    logic [POS_W-1:0] flen_m1;
    logic [POS_W-1:0] pn;
    logic [POS_W-1:0] off;
    logic [POS_W-1:0] k;
    logic             is_pcm;
    logic             right_half;
    logic             dly;
    logic             prior;
    logic             lsb;
    logic             active;
    logic [MAX_W-1:0] src;

    function automatic logic pick(input logic [MAX_W-1:0] s,
                                  input logic [POS_W-1:0] kk,
                                  input logic [IDX_W-1:0] w,
                                  input logic             lsb_first);
        logic [POS_W-1:0] idx;
        logic [SEL_W-1:0] sel;
        if (kk >= POS_W'(w)) return 1'b0;
        idx = lsb_first ? kk : (POS_W'(w) - POS_W'(1) - kk);
        sel = SEL_W'(idx);
        return s[sel];
    endfunction

    always_comb begin
        d          = q;
        is_pcm     = (cfg_fmt == FMT_PCM);
        slot       = POS_W'(cfg_slot_w);
        flen_m1    = is_pcm ? (slot - POS_W'(1)) : ((slot << 1) - POS_W'(1));
        pn         = (q.started && q.pos != flen_m1) ? (q.pos + POS_W'(1)) : '0;
        load       = fall && (pn == '0);
        right_half = !is_pcm && (pn >= slot);
        off        = right_half ? (pn - slot) : pn;
        dly        = (cfg_fmt == FMT_I2S) ? 1'b1 : (is_pcm ? cfg_pcm_delay : 1'b0);
        lsb        = is_pcm && cfg_lsb_first;
        prior      = dly && (off == '0);
        active     = cfg_long_sync ? (pn < (slot >> 1)) : (pn == '0);

        if (prior) begin
            // last bit of the slot before this one
            src = (!is_pcm && !right_half) ? cur_r : cur_l;
            k   = slot - POS_W'(1);
        end else begin
            src = right_half ? cur_r : ((pn == '0) ? nxt_l : cur_l);
            k   = off - POS_W'(dly);
        end

        if (fall) begin
            d.started = 1'b1;
            d.pos     = pn;
            d.sd      = pick(src, k, cfg_sample_w, lsb);
            case (cfg_fmt)
                FMT_I2S: d.fs = right_half;
                FMT_LJ:  d.fs = !right_half;
                default: d.fs = cfg_sync_pol ? active : !active;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fsync = q.fs;
    assign sdata = q.sd;

    // R1: serial outputs update only on a bit clock fall
    a_r1_fs_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.fs) |-> $past(fall));

    a_r1_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sd) |-> $past(fall));

    // R2: in the delayed stereo format frame sync rises only at the right slot start
    a_r2_right_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fmt == FMT_I2S && $rose(q.fs)) |-> (q.pos == slot));

    // R6: a short pulse is idle everywhere but bit period 0
    a_r6_short_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pcm && !cfg_long_sync && q.started && q.pos != '0) |-> (q.fs == !cfg_sync_pol));

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx #(
    parameter int MAX_W = 32,
    parameter int DIV_W = 8,
    localparam int IDX_W = $clog2(MAX_W + 1),
    localparam int POS_W = $clog2(2 * MAX_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_fmt,
    input  logic [IDX_W-1:0] cfg_sample_w,
    input  logic [IDX_W-1:0] cfg_slot_w,
    input  logic             cfg_lsb_first,
    input  logic             cfg_pcm_delay,
    input  logic             cfg_long_sync,
    input  logic             cfg_sync_pol,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [MAX_W-1:0] in_left,
    input  logic [MAX_W-1:0] in_right,
    output logic             bclk,
    output logic             fsync,
    output logic             sdata,
    output logic             underrun
);

    logic             fall;
    logic             load;
    logic [MAX_W-1:0] cur_l;
    logic [MAX_W-1:0] cur_r;
    logic [MAX_W-1:0] nxt_l;

    ast_bclk_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_div (cfg_div),
        .bclk    (bclk),
        .fall    (fall)
    );

    ast_sample_buf #(.MAX_W(MAX_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_left  (in_left),
        .in_right (in_right),
        .load     (load),
        .cur_l    (cur_l),
        .cur_r    (cur_r),
        .nxt_l    (nxt_l),
        .underrun (underrun)
    );

    ast_frame_seq #(.MAX_W(MAX_W), .IDX_W(IDX_W), .POS_W(POS_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .fall          (fall),
        .cfg_fmt       (cfg_fmt),
        .cfg_sample_w  (cfg_sample_w),
        .cfg_slot_w    (cfg_slot_w),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_pcm_delay (cfg_pcm_delay),
        .cfg_long_sync (cfg_long_sync),
        .cfg_sync_pol  (cfg_sync_pol),
        .cur_l         (cur_l),
        .cur_r         (cur_r),
        .nxt_l         (nxt_l),
        .load          (load),
        .fsync         (fsync),
        .sdata         (sdata)
    );

    // R1: port-level view, data line moves together with a bit clock fall
    a_r1_port_data_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> $fell(bclk));

    // R8: a pair accepted with nothing waiting closes the handshake next cycle
    a_r8_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

endmodule

// File: tb/audio_serial_tx_tb_top.sv
module audio_serial_tx_tb_top;

    localparam int MAX_W = 32;
    localparam int DIV_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_fmt = '0;
    logic [5:0]        cfg_sample_w = 6'd16;
    logic [5:0]        cfg_slot_w = 6'd16;
    logic              cfg_lsb_first = 1'b0;
    logic              cfg_pcm_delay = 1'b0;
    logic              cfg_long_sync = 1'b0;
    logic              cfg_sync_pol = 1'b0;
    logic [DIV_W-1:0]  cfg_div = 8'd2;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [MAX_W-1:0]  in_left = '0;
    logic [MAX_W-1:0]  in_right = '0;
    logic              bclk, fsync, sdata, underrun;

    always #5 clk = ~clk;

    audio_serial_tx #(.MAX_W(MAX_W), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_sample_w(cfg_sample_w),
        .cfg_slot_w(cfg_slot_w), .cfg_lsb_first(cfg_lsb_first), .cfg_pcm_delay(cfg_pcm_delay),
        .cfg_long_sync(cfg_long_sync), .cfg_sync_pol(cfg_sync_pol), .cfg_div(cfg_div),
        .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
        .bclk(bclk), .fsync(fsync), .sdata(sdata), .underrun(underrun)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    int m_cnt, m_bclk, m_pos, m_started, m_pend, m_under, m_fs, m_sd, m_carry, m_acc;
    logic [31:0] m_pl, m_pr, m_cl, m_cr;
    int fs_arr[128];
    int sd_arr[128];
    int stream[128];
    int supply_on;
    logic [31:0] seed = 32'h1234_5678;
    string tag_fs, tag_sd;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int sbit(input logic [31:0] s, input int k, input int w, input int lsb);
        if (k >= w) return 0;
        return lsb ? int'(s[k]) : int'(s[w-1-k]);
    endfunction

    task automatic build_frame();
        int slot, flen, dly, lsb, nch, lng_len;
        slot = int'(cfg_slot_w);
        nch  = (cfg_fmt == 2) ? 1 : 2;
        flen = nch * slot;
        lsb  = (cfg_fmt == 2) ? int'(cfg_lsb_first) : 0;
        dly  = (cfg_fmt == 0) ? 1 : ((cfg_fmt == 1) ? 0 : int'(cfg_pcm_delay));
        lng_len = slot / 2;
        for (int b = 0; b < slot; b++) begin
            stream[b] = sbit(m_cl, b, int'(cfg_sample_w), lsb);
            if (nch == 2) stream[slot + b] = sbit(m_cr, b, int'(cfg_sample_w), lsb);
        end
        for (int p = 0; p < flen; p++) begin
            sd_arr[p] = (p < dly) ? m_carry : stream[p - dly];
            case (cfg_fmt)
                2'd0: fs_arr[p] = (p < slot) ? 0 : 1;
                2'd1: fs_arr[p] = (p < slot) ? 1 : 0;
                default: begin
                    int act;
                    act = cfg_long_sync ? ((p < lng_len) ? 1 : 0) : ((p == 0) ? 1 : 0);
                    fs_arr[p] = cfg_sync_pol ? act : 1 - act;
                end
            endcase
        end
        m_carry = stream[flen - 1];
    endtask

    task automatic model_reset();
        m_cnt = 0; m_bclk = 1; m_pos = 0; m_started = 0; m_pend = 0;
        m_under = 0; m_fs = 0; m_sd = 0; m_carry = 0; m_acc = 0;
        m_pl = '0; m_pr = '0; m_cl = '0; m_cr = '0;
    endtask

    task automatic model_step();
        int tick, fall, pn, flen;
        m_acc = (in_valid && m_pend == 0) ? 1 : 0;
        tick  = (m_cnt == int'(cfg_div) - 1) ? 1 : 0;
        fall  = tick && m_bclk;
        flen  = (cfg_fmt == 2) ? int'(cfg_slot_w) : 2 * int'(cfg_slot_w);
        if (fall) begin
            pn = m_started ? (m_pos + 1) % flen : 0;
            if (pn == 0) begin
                if (m_pend) begin
                    m_cl = m_pl; m_cr = m_pr; m_pend = 0;
                end else begin
                    m_under = 1;
                end
                build_frame();
            end
            m_pos = pn; m_started = 1;
            m_fs = fs_arr[pn]; m_sd = sd_arr[pn];
        end
        if (m_acc) begin
            m_pend = 1; m_pl = in_left; m_pr = in_right;
        end
        if (tick) begin
            m_cnt = 0; m_bclk = 1 - m_bclk;
        end else begin
            m_cnt++;
        end
    endtask

    task automatic compare();
        check(int'(bclk) == m_bclk, "R1", "bclk", int'(bclk), m_bclk);
        check(int'(fsync) == m_fs, tag_fs, "fsync", int'(fsync), m_fs);
        check(int'(sdata) == m_sd, tag_sd, "sdata", int'(sdata), m_sd);
        check(int'(in_ready) == 1 - m_pend, "R8", "in_ready", int'(in_ready), 1 - m_pend);
        check(int'(underrun) == m_under, "R9", "underrun", int'(underrun), m_under);
    endtask

    task automatic drive();
        if (supply_on != 0) begin
            if (m_acc != 0 || !in_valid) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                in_left = seed;
                seed = seed * 32'd1103515245 + 32'd12345;
                in_right = seed;
            end
            in_valid = 1'b1;
        end else begin
            in_valid = 1'b0;
        end
    endtask

    task automatic run(input int fmt, input int sw, input int slw, input int lsb, input int dly,
                       input int lng, input int pol, input int dv, input int cycles,
                       input int starve_at, input string tfs, input string tsd);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        cfg_fmt = 2'(fmt); cfg_sample_w = 6'(sw); cfg_slot_w = 6'(slw);
        cfg_lsb_first = 1'(lsb); cfg_pcm_delay = 1'(dly); cfg_long_sync = 1'(lng);
        cfg_sync_pol = 1'(pol); cfg_div = 8'(dv);
        tag_fs = tfs; tag_sd = tsd;
        repeat (2) @(negedge clk);
        // R10: reset state
        check(bclk == 1'b1, "R10", "reset bclk", int'(bclk), 1);
        check(fsync == 1'b0, "R10", "reset fsync", int'(fsync), 0);
        check(sdata == 1'b0, "R10", "reset sdata", int'(sdata), 0);
        check(in_ready == 1'b1, "R10", "reset in_ready", int'(in_ready), 1);
        check(underrun == 1'b0, "R10", "reset underrun", int'(underrun), 0);
        model_reset();
        supply_on = 1;
        rst_n = 1'b1;
        drive();
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            model_step();
            compare();
            if (starve_at != 0 && c == starve_at) supply_on = 0;
            drive();
        end
        if (starve_at != 0)
            check(underrun == 1'b1, "R9", "underrun after stall", int'(underrun), 1);
    endtask

    initial begin
        // R2 R3: delayed stereo, full slots
        run(0, 16, 16, 0, 0, 0, 0, 2, 1200, 0, "R2", "R3");
        // R5: delayed stereo, 16-bit sample in 32-bit slot, fastest divider
        run(0, 16, 32, 0, 0, 0, 0, 1, 900, 0, "R2", "R5");
        // R4 R5: left-aligned, 24 in 32
        run(1, 24, 32, 0, 0, 0, 0, 3, 2000, 0, "R4", "R4");
        // R6 R7: mono, short active-high pulse, data one bit late, msb first
        run(2, 8, 8, 0, 1, 0, 1, 2, 800, 0, "R6", "R7");
        // R6 R7: mono, long active-low pulse, lsb first, 12 in 16, no delay
        run(2, 12, 16, 1, 0, 1, 0, 2, 1200, 0, "R6", "R7");
        // R6 R7: mono, long active-high pulse, lsb first with delay, 32-bit
        run(2, 32, 32, 1, 1, 1, 1, 1, 900, 0, "R6", "R7");
        // R9: delayed stereo with supply stopping part way
        run(0, 16, 16, 0, 0, 0, 0, 2, 1200, 300, "R2", "R9");
        // R9 R4: left-aligned, starved from early on
        run(1, 8, 16, 0, 0, 0, 0, 2, 800, 40, "R4", "R9");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule